// File: doc/BRIEF.md
# DMA Read Line Buffer Cache

This block sits between the narrow word-read port of a DMA engine and a wide system memory bus. It holds four 32-byte line buffers. When the DMA issues a short read that continues exactly where its previous read stopped, and that address lies in a buffered line, the word is returned from the buffer without any memory traffic. Every other aligned read fetches the whole 32-byte aligned line that contains the address in one memory transaction. It then returns the requested word and keeps the line for later sequential reads.

Other bus masters can write memory at any time. The block watches a snoop port that carries their write addresses. Any buffered line that a write touches is dropped, so a later read fetches fresh data. This holds for a write that lands in the same cycle as a read request. It also holds for a write that lands while the affected line is still being fetched. Lines are replaced in round-robin order. A read whose word address is not 4-byte aligned is rejected with an error strobe.

Top module: `dma_line_cache`

## Requirements
- R1: A fetch drives `mem_addr` with the read address with its five low bits cleared, and holds `mem_req` and `mem_addr` steady until `mem_ack`. `mem_data` carries the whole line, with word k at bits [32k+31:32k]. The returned word is the one selected by `rd_addr[4:2]`.
- R2: A request with `rd_addr[1:0]` not zero gives `rsp_err` high for one cycle, one cycle after acceptance. It gives no `rsp_valid` and no fetch. It leaves the buffers and the sequential-address tracking unchanged.
- R3: A read with `rd_len` of 32 or more always fetches from memory, even when it is sequential and its line is buffered.
- R4: A read with `rd_len` below 32 is served from a buffer when two conditions hold. Its address must equal the previous accepted aligned read's address plus that read's `rd_len`, and it must fall in a valid buffered line. It then gets `rsp_valid` exactly one cycle after acceptance and causes no fetch. For example, 4 bytes at 0x2340 followed by 4 bytes at 0x2344 gives one fetch.
- R5: A non-sequential read fetches even when its line is buffered. A refetch of a buffered line overwrites the buffer that already holds it, so no line is ever held twice.
- R6: A snoop write to any byte of a buffered line invalidates that line, and the next read of it fetches. A snoop to a different line leaves the buffers usable.
- R7: If a snoop write and a read request to the same line fall in the same cycle, the read is handled as a miss.
- R8: A snoop to the line being fetched leaves the filled buffer invalid. This applies in any cycle after acceptance, up to and including the `mem_ack` cycle. The response is still delivered with the word from `mem_data`.
- R9: On a fetch, `rd_ready` stays low from acceptance until the response. `rsp_valid` rises one cycle after the cycle in which `mem_ack` is high.
- R10: A fetch for a line that is not buffered replaces buffers in round-robin order, starting at buffer 0 after reset. A refetch of a buffered line does not advance the order.
- R11: After reset `rd_ready` is 1, `rsp_valid`, `rsp_err` and `mem_req` are 0, and no line is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | DMA read request, accepted when `rd_ready` is high |
| rd_addr | input | 32 | Byte address of the requested word |
| rd_len | input | 7 | Byte length of the DMA transfer this read belongs to |
| rd_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | Read data strobe |
| rsp_data | output | 32 | Read data word |
| rsp_err | output | 1 | Misaligned request strobe |
| mem_req | output | 1 | Line fetch request, held until acknowledged |
| mem_addr | output | 32 | Aligned line address of the fetch |
| mem_ack | input | 1 | Fetch completion, data valid this cycle |
| mem_data | input | 256 | Fetched line |
| snp_valid | input | 1 | Write by another bus master |
| snp_addr | input | 32 | Byte address of that write |

## Verification
The snoop invalidation can coincide with two other functions: a lookup of the same line, and the completion of a fill for that line. The bench raises the snoop together with a read request to a buffered line. It also raises the snoop in the same cycle as `mem_ack`, and in the first waiting cycle of a fetch. In every case the bench model advances the memory contents version as the write happens. It then judges the outcome by what follows. The next read of that line must cause a new fetch and return the new version, and the response to the colliding fetch must carry the word the memory delivered.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } dlc_state_e;

endpackage

// File: rtl/dlc_tag_cmp.sv
// Parallel comparison of a probe tag against every buffered line tag.
module dlc_tag_cmp #(
    parameter int N     = 4,
    parameter int TAG_W = 27
) (
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [N-1:0]            valid_i,
    input  logic [TAG_W-1:0]        probe_i,
    output logic [N-1:0]            match_o
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tags_i[g] == probe_i);
    end

endmodule

// File: rtl/dlc_victim.sv
// Round-robin replacement pointer.
module dlc_victim #(
    parameter int N     = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [IDX_W-1:0] ptr_o
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance_i) begin
            if (ptr_q == IDX_W'(N - 1)) ptr_d = '0;
            else                        ptr_d = ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/dlc_line_store.sv
// Line data storage: one whole-line write port, one word read port.
module dlc_line_store #(
    parameter int N      = 4,
    parameter int LINE_W = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W  = (N > 1) ? $clog2(N) : 1,
    localparam int WSEL_W = $clog2(LINE_W / WORD_W)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LINE_W-1:0] wr_line_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [WSEL_W-1:0] rd_wsel_i,
    output logic [WORD_W-1:0] rd_word_o
);

    logic [N-1:0][LINE_W-1:0] data_d, data_q;

    always_comb begin
        data_d = data_q;
        if (wr_en_i) data_d[wr_idx_i] = wr_line_i;
    end

    always_ff @(posedge clk) begin
        data_q <= data_d;
    end

    assign rd_word_o = data_q[rd_idx_i][rd_wsel_i*WORD_W +: WORD_W];

endmodule

// File: rtl/dma_line_cache.sv
module dma_line_cache
    import dlc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 4,
    localparam int WORD_BYTES = WORD_W / 8,
    localparam int OFS_W      = $clog2(LINE_BYTES),
    localparam int WOFS_W     = $clog2(WORD_BYTES),
    localparam int WSEL_W     = OFS_W - WOFS_W,
    localparam int TAG_W      = ADDR_W - OFS_W,
    localparam int LINE_W     = LINE_BYTES * 8,
    localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int LEN_W      = OFS_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [LEN_W-1:0]  rd_len,
    output logic              rd_ready,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_data,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr
);

    typedef struct packed {
        dlc_state_e                         state;
        logic [NUM_LINES-1:0][TAG_W-1:0]    tags;
        logic [NUM_LINES-1:0]               valid;
        logic [TAG_W-1:0]                   ftag;
        logic [IDX_W-1:0]                   fslot;
        logic [WSEL_W-1:0]                  fwsel;
        logic                               kill;
        logic                               seq_ok;
        logic [ADDR_W-1:0]                  seq_addr;
        logic                               rsp_valid;
        logic                               rsp_err;
        logic [WORD_W-1:0]                  rsp_data;
    } dlc_st_t;

    dlc_st_t st_d, st_q;

    logic [TAG_W-1:0]     rd_tag, snp_tag;
    logic [NUM_LINES-1:0] snp_hit, look_hit, valid_eff;
    logic [IDX_W-1:0]     hit_idx, vic_ptr;
    logic                 vic_adv;
    logic                 st_wr_en;
    logic [WORD_W-1:0]    buf_word;
    logic                 fetch_snooped;
    logic                 accept;
    logic                 snp_lo_unused;

    assign rd_tag        = rd_addr[ADDR_W-1:OFS_W];
    assign snp_tag       = snp_addr[ADDR_W-1:OFS_W];
    assign snp_lo_unused = ^snp_addr[OFS_W-1:0];

    // Snoop lookup against currently valid lines
    dlc_tag_cmp #(.N(NUM_LINES), .TAG_W(TAG_W)) u_snp_cmp (
        .tags_i  (st_q.tags),
        .valid_i (st_q.valid & {NUM_LINES{snp_valid}}),
        .probe_i (snp_tag),
        .match_o (snp_hit)
    );

    // A same-cycle snoop removes the line before the read looks it up
    assign valid_eff = st_q.valid & ~snp_hit;

    dlc_tag_cmp #(.N(NUM_LINES), .TAG_W(TAG_W)) u_rd_cmp (
        .tags_i  (st_q.tags),
        .valid_i (valid_eff),
        .probe_i (rd_tag),
        .match_o (look_hit)
    );

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (look_hit[i]) hit_idx = IDX_W'(i);
        end
    end

    dlc_victim #(.N(NUM_LINES)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (vic_adv),
        .ptr_o     (vic_ptr)
    );

    dlc_line_store #(.N(NUM_LINES), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .wr_en_i   (st_wr_en),
        .wr_idx_i  (st_q.fslot),
        .wr_line_i (mem_data),
        .rd_idx_i  (hit_idx),
        .rd_wsel_i (rd_addr[OFS_W-1:WOFS_W]),
        .rd_word_o (buf_word)
    );

    assign accept        = rd_req && (st_q.state == ST_IDLE);
    assign fetch_snooped = snp_valid && (snp_tag == st_q.ftag);

    always_comb begin
        st_d           = st_q;
        st_d.valid     = valid_eff;
        st_d.rsp_valid = 1'b0;
        st_d.rsp_err   = 1'b0;
        vic_adv        = 1'b0;
        st_wr_en       = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (rd_addr[WOFS_W-1:0] != '0) begin
                        st_d.rsp_err = 1'b1;
                    end else begin
                        st_d.seq_ok   = 1'b1;
                        st_d.seq_addr = rd_addr + ADDR_W'(rd_len);
                        if ((rd_len < LEN_W'(LINE_BYTES)) && st_q.seq_ok &&
                            (rd_addr == st_q.seq_addr) && (|look_hit)) begin
                            st_d.rsp_valid = 1'b1;
                            st_d.rsp_data  = buf_word;
                        end else begin
                            st_d.state = ST_FETCH;
                            st_d.ftag  = rd_tag;
                            st_d.fwsel = rd_addr[OFS_W-1:WOFS_W];
                            st_d.kill  = 1'b0;
                            if (|look_hit) begin
                                st_d.fslot = hit_idx;
                            end else begin
                                st_d.fslot = vic_ptr;
                                vic_adv    = 1'b1;
                            end
                            st_d.tags[st_d.fslot]  = rd_tag;
                            st_d.valid[st_d.fslot] = 1'b0;
                        end
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    st_wr_en                = 1'b1;
                    st_d.valid[st_q.fslot]  = !(st_q.kill || fetch_snooped);
                    st_d.rsp_valid          = 1'b1;
                    st_d.rsp_data           = mem_data[st_q.fwsel*WORD_W +: WORD_W];
                    st_d.state              = ST_IDLE;
                end else if (fetch_snooped) begin
                    st_d.kill = 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_ready  = (st_q.state == ST_IDLE);
    assign mem_req   = (st_q.state == ST_FETCH);
    assign mem_addr  = {st_q.ftag, {OFS_W{1'b0}}};
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_err   = st_q.rsp_err;
    assign rsp_data  = st_q.rsp_data;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R1

    AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && (rd_addr[WOFS_W-1:0] != '0)) |=> (rsp_err && !rsp_valid && !mem_req)); // R2

    AST_LONG_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && (rd_addr[WOFS_W-1:0] == '0) && (rd_len >= LEN_W'(LINE_BYTES))) |=> mem_req); // R3

    AST_NO_DUP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hit)); // R5

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|snp_hit) |=> ((st_q.valid & $past(snp_hit)) == '0)); // R6

    AST_SAME_CYCLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready && (rd_addr[WOFS_W-1:0] == '0) && snp_valid && (snp_tag == rd_tag)) |=> mem_req); // R7

    AST_FILL_KILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && fetch_snooped) |=> !st_q.valid[$past(st_q.fslot)]); // R8

    AST_ACK_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (rsp_valid && !mem_req && rd_ready)); // R9

endmodule

// File: tb/sim_dma_line_cache.sv
module sim_dma_line_cache;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int NVEC       = 25;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_req = 1'b0;
    logic [31:0]  rd_addr = '0;
    logic [6:0]   rd_len = '0;
    logic         rd_ready;
    logic         rsp_valid;
    logic [31:0]  rsp_data;
    logic         rsp_err;
    logic         mem_req;
    logic [31:0]  mem_addr;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_data = '0;
    logic         snp_valid = 1'b0;
    logic [31:0]  snp_addr = '0;

    int checks = 0;
    int errors = 0;
    logic [7:0] ver = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_line_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_ready(rd_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_data(mem_data),
        .snp_valid(snp_valid), .snp_addr(snp_addr)
    );

    // {addr[31:0], len[6:0], expect_fetch}
    localparam logic [39:0] VEC [NVEC] = '{
        {32'h0000_2340, 7'd4,  1'b1},  // R4 R11 first read fetches
        {32'h0000_2344, 7'd4,  1'b0},  // R4 sequential hit
        {32'h0000_2348, 7'd4,  1'b0},  // R4
        {32'h0000_2340, 7'd4,  1'b1},  // R5 non-sequential refetch, buffer 0
        {32'h0000_1060, 7'd4,  1'b1},  // R10 buffer 1
        {32'h0000_1040, 7'd4,  1'b1},  // R10 buffer 2
        {32'h0000_1020, 7'd4,  1'b1},  // R10 buffer 3
        {32'h0000_1000, 7'd4,  1'b1},  // R10 wraps to buffer 0
        {32'h0000_1000, 7'd4,  1'b1},  // R5 refetch in place, no advance
        {32'h0000_1004, 7'd24, 1'b0},  // R4
        {32'h0000_101C, 7'd4,  1'b0},  // R4
        {32'h0000_1020, 7'd28, 1'b0},  // R4 next line still held
        {32'h0000_103C, 7'd4,  1'b0},  // R4
        {32'h0000_1040, 7'd28, 1'b0},  // R4
        {32'h0000_105C, 7'd4,  1'b0},  // R4
        {32'h0000_1060, 7'd4,  1'b0},  // R4
        {32'h0000_3000, 7'd4,  1'b1},  // R10 replaces buffer 1 (0x1060)
        {32'h0000_1000, 7'd4,  1'b1},  // R5 refetch in place
        {32'h0000_1004, 7'd28, 1'b0},  // R10 0x1000 kept
        {32'h0000_1020, 7'd28, 1'b0},  // R10 0x1020 kept
        {32'h0000_103C, 7'd4,  1'b0},  // R4
        {32'h0000_1040, 7'd28, 1'b0},  // R10 0x1040 kept
        {32'h0000_105C, 7'd4,  1'b0},  // R4
        {32'h0000_1060, 7'd4,  1'b1},  // R10 0x1060 was the victim
        {32'h0000_1064, 7'd32, 1'b1}   // R3 long sequential read fetches
    };

    function automatic logic [31:0] word_of(input logic [31:0] a, input logic [7:0] v);
        return {a[31:2], 2'b00} ^ {v, 24'h0};
    endfunction

    function automatic logic [255:0] line_of(input logic [31:0] a, input logic [7:0] v);
        logic [255:0] r;
        for (int w = 0; w < 8; w++) r[w*32 +: 32] = word_of({a[31:5], 5'b0} + 32'(w*4), v);
        return r;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // mode: 0 none, 1 snoop in ack cycle, 2 snoop with request, 3 snoop in first fetch cycle
    task automatic read_op(input logic [31:0] addr, input int len, input bit exp_fetch,
                           input int mode, input string req);
        logic [7:0]  rver;
        logic [31:0] faddr;
        logic [31:0] expw;
        int cyc, wcnt;
        bit fetched, got, busy;
        @(negedge clk);
        rd_req = 1'b1; rd_addr = addr; rd_len = 7'(len);
        if (mode == 2) begin snp_valid = 1'b1; snp_addr = addr; ver = ver + 1'b1; end
        @(negedge clk);
        rd_req = 1'b0; snp_valid = 1'b0;
        cyc = 0; wcnt = 0; fetched = 0; got = 0; busy = 1; rver = ver; faddr = '0;
        while (!got && cyc < 200) begin
            if (rsp_valid || rsp_err) begin
                got = 1;
            end else begin
                if (rd_ready) busy = 0;
                if (mem_req) begin
                    if (mode == 3 && wcnt == 0) begin
                        snp_valid = 1'b1; snp_addr = mem_addr + 32'd28; ver = ver + 1'b1;
                    end
                    wcnt++;
                    if (wcnt == MEM_LAT) begin
                        mem_ack = 1'b1; rver = ver; mem_data = line_of(mem_addr, ver);
                        fetched = 1; faddr = mem_addr;
                        if (mode == 1) begin
                            snp_valid = 1'b1; snp_addr = mem_addr + 32'd8; ver = ver + 1'b1;
                        end
                    end
                end
                @(negedge clk);
                mem_ack = 1'b0; snp_valid = 1'b0;
                cyc++;
            end
        end
        chk(got && rsp_valid && !rsp_err, {req, " R9 response delivered"}, {30'b0, rsp_err, rsp_valid}, 32'h1);
        chk(fetched == exp_fetch, {req, " fetch decision"}, 32'(fetched), 32'(exp_fetch));
        if (fetched) begin
            chk(faddr == {addr[31:5], 5'b0}, {req, " R1 fetch line address"}, faddr, {addr[31:5], 5'b0});
            chk(cyc == MEM_LAT && busy, {req, " R9 miss latency and busy"}, 32'(cyc), 32'(MEM_LAT));
        end else begin
            chk(cyc == 0, {req, " R4 hit latency"}, 32'(cyc), 32'h0);
        end
        expw = word_of(addr, fetched ? rver : ver);
        chk(rsp_data == expw, {req, " R1 returned word"}, rsp_data, expw);
    endtask

    task automatic snoop(input logic [31:0] a, input bit bump);
        @(negedge clk);
        snp_valid = 1'b1; snp_addr = a;
        if (bump) ver = ver + 1'b1;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(rd_ready && !rsp_valid && !rsp_err && !mem_req, "R11 reset outputs",
            {28'b0, rd_ready, rsp_valid, rsp_err, mem_req}, 32'h8);

        for (int i = 0; i < NVEC; i++) begin
            read_op(VEC[i][39:8], int'(VEC[i][7:1]), VEC[i][0], 0, $sformatf("vec%0d", i));
        end

        // R2 misaligned request is rejected and disturbs nothing
        read_op(32'h0000_4000, 4, 1'b1, 0, "R2 setup");
        @(negedge clk);
        rd_req = 1'b1; rd_addr = 32'h0000_4005; rd_len = 7'd4;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rsp_err && !rsp_valid && !mem_req, "R2 misaligned error strobe",
            {29'b0, rsp_err, rsp_valid, mem_req}, 32'h4);
        @(negedge clk);
        chk(!rsp_err && !mem_req, "R2 error is one cycle", {30'b0, rsp_err, mem_req}, 32'h0);
        read_op(32'h0000_4004, 4, 1'b0, 0, "R2 sequence kept");

        // R6 snoop to neighbouring line has no effect
        snoop(32'h0000_4020, 1'b0);
        read_op(32'h0000_4008, 4, 1'b0, 0, "R6 other line");
        // R6 snoop to last byte of the held line invalidates it
        snoop(32'h0000_401F, 1'b1);
        read_op(32'h0000_400C, 4, 1'b1, 0, "R6 invalidated");

        // R7 snoop in the same cycle as a sequential hit candidate
        read_op(32'h0000_4010, 4, 1'b1, 2, "R7 same cycle");

        // R8 snoop in the ack cycle
        read_op(32'h0000_6000, 4, 1'b1, 1, "R8 ack cycle fill");
        read_op(32'h0000_6004, 4, 1'b1, 0, "R8 killed line refetched");
        // R8 snoop in the first fetch cycle
        read_op(32'h0000_7000, 4, 1'b1, 3, "R8 mid fetch fill");
        read_op(32'h0000_7004, 4, 1'b1, 0, "R8 killed line refetched");
        read_op(32'h0000_7008, 4, 1'b0, 0, "R4 clean fill usable");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule